// File: doc/BRIEF.md
# Serial Interface Bit-Rate Generator

This block derives the timing strobes for a serial transmitter and receiver from the internal bus clock. The core runs on a fast clock. A bus-clock enable input marks the bus cycles, which occur at one quarter of the core rate. Every divider in the block advances only on cycles where that enable is high. Software selects the bit rate through one 8-bit control register. The register sets a coarse prescaler factor of 1, 3, 4 or 13, followed by a binary rate divider of 2^R with R from 0 to 7.

The block produces two one-cycle strobes. The first is an oversampling strobe at sixteen times the bit rate, which the receiver uses to sample the line. The second is a bit-period strobe on every sixteenth oversampling strobe. Any write to the register restarts both dividers, so the new rate takes effect from a clean phase. A strap input selects a bootstrap setting that is loaded when reset is released. Two test bits in the register are kept for software but do not change the timing.

Top module: `sbr_baudgen`

## Requirements
- R1: A write stores `wr_data` into the control register, except bit 6, which always reads 0. `rd_data` shows the stored register at all times, and the register keeps its value until the next write. Bit layout: bit 7 is a test bit, bits 5:4 are the prescaler select, bit 3 is a test bit, and bits 2:0 are the rate select R.
- R2: While reset is asserted, `rd_data` is 0x00 and both strobes are low. On the first clock after the synchronised reset release, the register loads 0x00 if `boot_mode` is low and 0x33 if it is high. The 0x33 setting gives factor 13 and R = 3.
- R3: The oversampling strobe `os_tick` fires once every F × 2^R bus-enable pulses. F is set by bits 5:4 as follows: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13. `os_tick` is high for the single clock that follows the edge that took the final pulse.
- R4: The bit strobe `bit_tick` is high only together with `os_tick`. It fires on every 16th oversampling strobe, so its period is 16 × F × 2^R bus-enable pulses.
- R5: Clock cycles with `bus_ce` low do not advance either divider, whatever the enable pattern.
- R6: Every write restarts both dividers, even a write of an unchanged value. A `bus_ce` pulse in the write cycle is not counted. The first `os_tick` comes exactly F × 2^R pulses after the write, and the first `bit_tick` comes 16 times that many pulses after it. A write in the middle of a period discards the partial count.
- R7: Test bits 7 and 3 are stored and read back but do not change either strobe period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_mode | input | 1 | Strap that selects the bootstrap setting at reset release |
| bus_ce | input | 1 | Bus-clock enable: one pulse per bus cycle |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data for the control register |
| rd_data | output | 8 | Current control register contents |
| os_tick | output | 1 | Oversampling strobe at 16× the bit rate |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
The bench targets the restart rule. It measures the first strobe after every write, including a write that lands in the middle of a period; a divider that kept its partial count would deliver that first strobe early. It also runs the unchanged ratios under sparse and random `bus_ce` patterns, where a design that counted core cycles instead of bus cycles would show periods that are too short. Further cases cover the smallest divisor, where the strobe fires on every bus cycle, and the largest, where an undersized counter would wrap. Settings that differ only in the test bits are checked for identical periods, and the bootstrap strap is checked for period 104, which a design that ignored the strap would miss.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int REG_W  = 8;
  localparam int RATE_W = 3;
  localparam int PRE_W  = 4;

  localparam logic [REG_W-1:0] CFG_RESET_VAL = 8'h00;
  localparam logic [REG_W-1:0] CFG_BOOT_VAL  = 8'h33;
  localparam logic [REG_W-1:0] CFG_STORE_MASK = 8'hBF;

  typedef struct packed {
    logic              tst_clr;
    logic              rsvd;
    logic [1:0]        pre_sel;
    logic              tst_chk;
    logic [RATE_W-1:0] rate;
  } cfg_reg_t;

  function automatic logic [PRE_W-1:0] pre_factor(input logic [1:0] sel);
    logic [PRE_W-1:0] f;
    case (sel)
      2'b00:   f = PRE_W'(1);
      2'b01:   f = PRE_W'(3);
      2'b10:   f = PRE_W'(4);
      default: f = PRE_W'(13);
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sbr_rst_sync.sv
module sbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sbr_cfg_reg.sv
module sbr_cfg_reg
  import sbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [1:0]        pre_sel_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              restart_o
);

  logic [REG_W-1:0] reg_q, reg_d;
  logic             strap_q, strap_d;
  cfg_reg_t         view;

  always_comb begin
    reg_d   = reg_q;
    strap_d = 1'b0;
    if (wr_en) begin
      reg_d = wr_data & CFG_STORE_MASK;
    end else if (strap_q) begin
      reg_d = boot_mode ? CFG_BOOT_VAL : CFG_RESET_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= CFG_RESET_VAL;
      strap_q <= 1'b1;
    end else begin
      reg_q   <= reg_d;
      strap_q <= strap_d;
    end
  end

  assign view      = cfg_reg_t'(reg_q);
  assign rd_data   = reg_q;
  assign pre_sel_o = view.pre_sel;
  assign rate_o    = view.rate;
  assign restart_o = wr_en | strap_q;

  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & CFG_STORE_MASK)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !strap_q) |=> $stable(rd_data)); // R1
  AST_BOOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_q && !wr_en && boot_mode) |=> rd_data == CFG_BOOT_VAL); // R2

endmodule

// File: rtl/sbr_div_chain.sv
module sbr_div_chain
  import sbr_pkg::*;
#(
  parameter int OS_RATIO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic              restart,
  input  logic [1:0]        pre_sel,
  input  logic [RATE_W-1:0] rate,
  output logic              os_tick_o,
  output logic              bit_tick_o
);

  localparam int  CNT_W   = PRE_W + (2 ** RATE_W) - 1;
  localparam int  OS_W    = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
  localparam bit  OS_POW2 = (OS_RATIO == (2 ** OS_W));

  logic [CNT_W-1:0] div_val, term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OS_W-1:0]  sub_q, sub_d, sub_nxt;
  logic             sub_last;
  logic             os_q, os_d;
  logic             bit_q, bit_d;

  assign div_val = CNT_W'(pre_factor(pre_sel)) << rate;
  assign term    = div_val - CNT_W'(1);

  generate
    if (OS_POW2) begin : g_sub_wrap
      assign sub_last = &sub_q;
      assign sub_nxt  = sub_q + OS_W'(1);
    end else begin : g_sub_cmp
      assign sub_last = (sub_q == OS_W'(OS_RATIO - 1));
      assign sub_nxt  = sub_last ? '0 : sub_q + OS_W'(1);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    sub_d = sub_q;
    os_d  = 1'b0;
    bit_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
      sub_d = '0;
    end else if (bus_ce) begin
      if (cnt_q == term) begin
        cnt_d = '0;
        os_d  = 1'b1;
        sub_d = sub_nxt;
        bit_d = sub_last;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sub_q <= '0;
      os_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sub_q <= sub_d;
      os_q  <= os_d;
      bit_q <= bit_d;
    end
  end

  assign os_tick_o  = os_q;
  assign bit_tick_o = bit_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term); // R3
  AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick_o |-> os_tick_o); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && !restart) |=> ($stable(cnt_q) && !os_tick_o)); // R5
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!os_tick_o && !bit_tick_o && cnt_q == '0)); // R6

endmodule

// File: rtl/sbr_baudgen.sv
module sbr_baudgen
  import sbr_pkg::*;
#(
  parameter int OS_RATIO   = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_mode,
  input  logic             bus_ce,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             os_tick,
  output logic             bit_tick
);

  logic              rst_n_s;
  logic [1:0]        pre_sel;
  logic [RATE_W-1:0] rate;
  logic              restart;

  sbr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sbr_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .boot_mode (boot_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .pre_sel_o (pre_sel),
    .rate_o    (rate),
    .restart_o (restart)
  );

  sbr_div_chain #(.OS_RATIO(OS_RATIO)) u_div (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bus_ce     (bus_ce),
    .restart    (restart),
    .pre_sel    (pre_sel),
    .rate       (rate),
    .os_tick_o  (os_tick),
    .bit_tick_o (bit_tick)
  );

endmodule

// File: tb/tb_sbr_baudgen.sv
`timescale 1ns/1ps
module tb_sbr_baudgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_mode = 1'b0;
  logic       bus_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       os_tick, bit_tick;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int ce_pct = 100;
  int cur_div = 1;
  logic [7:0] cur_val = 8'h00;
  bit sparse = 1'b0;
  int bit_seen = 0;

  always #2.5 clk = ~clk;

  sbr_baudgen dut (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .bus_ce(bus_ce),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  function automatic int exp_div(input logic [7:0] v);
    int f;
    case (v[5:4])
      2'b00: f = 1;
      2'b01: f = 3;
      2'b10: f = 4;
      default: f = 13;
    endcase
    return f << v[2:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus enable driver
  initial begin
    forever begin
      @(posedge clk);
      #1 bus_ce = ($urandom % 100) < ce_pct;
    end
  end

  // strobe monitor, samples at the falling edge
  initial begin
    int ce_os, ce_bit, os_since_bit;
    bit os_ok, bit_ok, first_os, first_bit;
    string tag;
    ce_os = 0; ce_bit = 0; os_since_bit = 0;
    os_ok = 0; bit_ok = 0; first_os = 0; first_bit = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        os_ok = 0; bit_ok = 0; ce_os = 0; ce_bit = 0; os_since_bit = 0;
        continue;
      end
      if (bit_tick) begin
        check(os_tick, "R4 bit strobe without oversample strobe", 0, 1);
      end
      if (os_tick) begin
        if (first_os) tag = "R6";
        else if (cur_val[7] || cur_val[3]) tag = "R7";
        else if (sparse) tag = "R5";
        else tag = "R3";
        if (os_ok) check(ce_os == cur_div, {tag, " oversample period"}, ce_os, cur_div);
        os_ok = 1; first_os = 0; ce_os = 0; os_since_bit++;
      end
      if (bit_tick) begin
        tag = first_bit ? "R6" : "R4";
        if (bit_ok) begin
          check(ce_bit == 16 * cur_div, {tag, " bit period"}, ce_bit, 16 * cur_div);
          check(os_since_bit == 16, {tag, " strobes per bit"}, os_since_bit, 16);
        end
        bit_ok = 1; first_bit = 0; ce_bit = 0; os_since_bit = 0;
        bit_seen++;
      end
      if (wr_en) begin
        ce_os = 0; ce_bit = 0; os_since_bit = 0;
        os_ok = 1; bit_ok = 1; first_os = 1; first_bit = 1;
        cur_val = wr_data;
        cur_div = exp_div(wr_data);
      end else if (bus_ce) begin
        ce_os++; ce_bit++;
      end
    end
  end

  task automatic do_reset(input bit boot);
    @(posedge clk);
    #1 rst_n = 1'b0; boot_mode = boot;
    cur_val = boot ? 8'h33 : 8'h00;
    cur_div = exp_div(cur_val);
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R2 register in reset", rd_data, 0);
    check(!os_tick && !bit_tick, "R2 strobes in reset", {os_tick, bit_tick}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(rd_data == cur_val, "R2 register after release", rd_data, cur_val);
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    #1 wr_en = 1'b0;
    @(negedge clk);
    check(rd_data == (v & 8'hBF), "R1 readback", rd_data, v & 8'hBF);
  endtask

  task automatic wait_bits(input int n);
    int target;
    target = bit_seen + n;
    while (bit_seen < target) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic [7:0] v;
    seed_dummy = $urandom(32'd20240611);
    do_reset(1'b0);
    ce_pct = 100;
    write_reg(8'h00); wait_bits(2);
    write_reg(8'h00); wait_bits(2);   // R6 same-value rewrite restarts
    write_reg(8'h10); wait_bits(2);
    write_reg(8'h22); wait_bits(2);
    write_reg(8'h11); wait_bits(2);   // reference for R7
    write_reg(8'h99); wait_bits(2);   // R7 test bits set, same period
    write_reg(8'h88); wait_bits(2);
    write_reg(8'hFF);                 // R1 bit 6 reads zero
    check(rd_data == 8'hBF, "R1 reserved bit", rd_data, 8'hBF);
    wait_bits(1);
    sparse = 1'b1; ce_pct = 40;
    write_reg(8'h31); wait_bits(2);   // R5 sparse enable
    write_reg(8'h22);
    repeat (7) @(posedge clk);
    write_reg(8'h21); wait_bits(2);   // R6 mid-period rewrite
    for (int i = 0; i < 8; i++) begin
      v = 8'($urandom);
      v[2:0] = 3'(v[2:0] % 4);
      ce_pct = 50 + int'($urandom % 51);
      write_reg(v);
      if (v[0]) begin
        repeat (3) @(posedge clk);
        write_reg(v ^ 8'h10);
      end
      wait_bits(2);
    end
    sparse = 1'b0; ce_pct = 100;
    do_reset(1'b1);                   // R2 bootstrap strap
    wait_bits(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule